// File: doc/BRIEF.md
# Latched-Address Write-Once Byte Memory

This block models a byte-wide fuse memory with 8192 words, and it runs on a system clock. The block samples every control input on the rising clock edge. On the first edge that sees the active-low chip enable low after it was high, the block captures the address into a holding register. That captured address selects the word for the whole access, whatever the address pins do later in the access. The data bus is modelled as a tri-state pair. `dq_o` carries the data and `dq_drive_o` says when the pins would be driven. A separate active-low output enable gates the drive. The word is declared valid only after two programmable numbers of cycles have passed: one counted from chip enable going low, one counted from output enable going low.

Every fuse starts at 0. A programming pulse sets one fuse to 1, and nothing can clear it. The pulse needs program-enable low, chip enable low and output enable high. The bit to set is the one data input line that is pulled low. A pulse with more than one line low is refused and flagged.

A checker inside the block watches the chip-enable timing rules, counted in clock cycles. Each rule has its own sticky error bit. A reset clears the error bits and also returns the array to its blank state.

The read port has no back-pressure. `dq_valid_o` qualifies `dq_o` for every cycle in which it is high. A reader takes the word while the strobe is high, and the block never waits for the reader.

Top module: `otp_byte_rom`

## Requirements
- R1: The address is captured at the rising edge that first samples `ce_n_i` low after a high sample. Changing `addr_i` later in the same low period does not change the word shown on `dq_o`.
- R2: Suppose an edge samples `ce_n_i`=0, `oe_n_i`=0 and `pgm_n_i`=1. Then `dq_drive_o` is 1 after that edge. After any other combination, `dq_drive_o` is 0 (high impedance).
- R3: `dq_valid_o` is 1 only while `dq_drive_o` is 1, after at least CE_ACC edges with chip enable low and at least OE_ACC edges with output enable low. Defaults are CE_ACC=4 and OE_ACC=2. While `dq_valid_o` is 0, `dq_o` is all zeros.
- R4: After reset every word reads 0x00, including the first and last addresses.
- R5: A programming edge sets exactly one fuse of the captured word. Such an edge samples `ce_n_i`=0 with chip enable also low at the previous edge, `pgm_n_i`=0, `oe_n_i`=1, and exactly one `dq_i` line low. The fuse set is the bit whose line is low.
- R6: Programmed fuses never return to 0. A later pulse on another bit leaves the earlier bits set.
- R7: A programming edge with more than one `dq_i` line low writes nothing and sets `prog_reject_o`, which stays set until reset. A pulse with no line low writes nothing and raises no flag.
- R8: With `ce_n_i` high or `pgm_n_i` high, no fuse changes, whatever `dq_i` carries.
- R9: `rule_err_o` bit 0 (setup) is set when the capturing edge arrives and the address has not been sampled unchanged on at least SETUP_CYC (default 2) earlier edges. All `rule_err_o` bits stay set until reset.
- R10: `rule_err_o` bit 1 (hold) is set if `addr_i` differs from the captured address on any of the HOLD_CYC (default 3) edges after capture while chip enable is low.
- R11: `rule_err_o` bit 2 (low width) is set if chip enable rises after fewer than CE_LOW_MIN (default 15) low edges.
- R12: `rule_err_o` bit 3 (high width) is set if a capture follows fewer than CE_HIGH_MIN (default 5) high edges.
- R13: `rule_err_o` bit 4 (cycle) is set if two captures are fewer than CYCLE_MIN (default 22) edges apart. Correct timing leaves every bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears flags and fuses |
| addr_i | input | 13 | Word address |
| ce_n_i | input | 1 | Active-low chip enable; falling sample captures the address |
| oe_n_i | input | 1 | Active-low output enable |
| pgm_n_i | input | 1 | Active-low program enable |
| dq_i | input | 8 | Data bus as seen from outside; the low line picks the fuse to set |
| dq_o | output | 8 | Read data, zero when not valid |
| dq_drive_o | output | 1 | Bus drive enable; 0 means high impedance |
| dq_valid_o | output | 1 | Read data valid strobe |
| prog_reject_o | output | 1 | Sticky flag for a refused multi-line programming pulse |
| rule_err_o | output | 5 | Sticky timing-rule flags: setup, hold, low width, high width, cycle |

## Verification
The reads cover two orders of the enables. In one, output enable is low before chip enable falls. In the other, output enable falls long after capture. These show whether the valid strobe follows the chip-enable count or the output-enable count, and whether a late address change leaks into the data. Programming pulses are applied with one line low on the low and high bit positions, with no line low, with all lines low, and with chip enable high. These show a proper single-fuse set apart from a merge, a silent no-op and a refusal. Each timing rule is then broken on its own right after a reset. This shows that every error bit answers its own rule alone.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;
  localparam int RULE_N   = 5;
  localparam int RI_SETUP = 0;
  localparam int RI_HOLD  = 1;
  localparam int RI_LOW   = 2;
  localparam int RI_HIGH  = 3;
  localparam int RI_CYCLE = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/otp_addr_capture.sv
`timescale 1ns/1ps
module otp_addr_capture #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  output logic              ce_fall_o,
  output logic              ce_rise_o,
  output logic              ce_was_low_o,
  output logic [ADDR_W-1:0] addr_held_o
);
  logic ce_n_q;

  assign ce_fall_o    = ce_n_q & ~ce_n_i;
  assign ce_rise_o    = ~ce_n_q & ce_n_i;
  assign ce_was_low_o = ~ce_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q      <= 1'b1;
      addr_held_o <= '0;
    end else begin
      ce_n_q <= ce_n_i;
      if (ce_fall_o) addr_held_o <= addr_i;
    end
  end
endmodule

// File: rtl/otp_rule_check.sv
`timescale 1ns/1ps
module otp_rule_check
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 3,
  parameter int CE_LOW_MIN  = 15,
  parameter int CE_HIGH_MIN = 5,
  parameter int CYCLE_MIN   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              ce_fall_i,
  input  logic              ce_rise_i,
  input  logic [ADDR_W-1:0] addr_held_i,
  output logic [RULE_N-1:0] rule_err_o
);
  localparam int TOPV = imax(imax(CE_LOW_MIN, CE_HIGH_MIN),
                             imax(CYCLE_MIN, imax(SETUP_CYC, HOLD_CYC)));
  localparam int CW = $clog2(TOPV + 1) + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     stab_cnt, hold_left, lo_cnt, hi_cnt, cyc_cnt;
  logic [RULE_N-1:0] viol;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      stab_cnt  <= '0;
      hold_left <= '0;
      lo_cnt    <= '0;
      hi_cnt    <= '1;
      cyc_cnt   <= '1;
    end else begin
      addr_q    <= addr_i;
      stab_cnt  <= (addr_i == addr_q) ? bump(stab_cnt) : '0;
      hold_left <= ce_fall_i ? CW'(HOLD_CYC)
                 : ((hold_left != '0) ? hold_left - 1'b1 : '0);
      lo_cnt    <= ce_n_i ? '0 : bump(lo_cnt);
      hi_cnt    <= ce_n_i ? bump(hi_cnt) : '0;
      cyc_cnt   <= ce_fall_i ? CW'(1) : bump(cyc_cnt);
    end
  end

  assign viol[RI_SETUP] = ce_fall_i &&
    !((addr_i == addr_q) && (stab_cnt >= CW'(SETUP_CYC - 1)));
  assign viol[RI_HOLD]  = (hold_left != '0) && !ce_n_i && (addr_i != addr_held_i);
  assign viol[RI_LOW]   = ce_rise_i && (lo_cnt < CW'(CE_LOW_MIN));
  assign viol[RI_HIGH]  = ce_fall_i && (hi_cnt < CW'(CE_HIGH_MIN));
  assign viol[RI_CYCLE] = ce_fall_i && (cyc_cnt < CW'(CYCLE_MIN));

  for (genvar g = 0; g < RULE_N; g++) begin : g_sticky
    logic hit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit_q | viol[g];
    end
    assign rule_err_o[g] = hit_q;
  end
endmodule

// File: rtl/otp_fuse_array.sv
`timescale 1ns/1ps
module otp_fuse_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] set_mask_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] fuse_mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fuse_mem[i] <= '0;
    end else if (wr_en_i) begin
      fuse_mem[addr_i] <= fuse_mem[addr_i] | set_mask_i;
    end
  end

  assign rd_data_o = fuse_mem[addr_i];
endmodule

// File: rtl/otp_port_ctrl.sv
`timescale 1ns/1ps
module otp_port_ctrl
  import otp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CE_ACC = 4,
  parameter int OE_ACC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              pgm_n_i,
  input  logic              ce_was_low_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] set_mask_o,
  output logic              reject_o,
  output logic              drive_o,
  output logic              valid_o
);
  localparam int ACW = $clog2(imax(CE_ACC, OE_ACC) + 1);

  logic [ACW-1:0] ce_cnt, oe_cnt;
  logic           pulse;
  logic           one_low, many_low;

  function automatic logic [ACW-1:0] bump(input logic [ACW-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  assign set_mask_o = ~dq_i;
  assign pulse      = !ce_n_i && ce_was_low_i && !pgm_n_i && oe_n_i;
  assign one_low    = ($countones(set_mask_o) == 1);
  assign many_low   = ($countones(set_mask_o) > 1);
  assign wr_en_o    = pulse && one_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_cnt   <= '0;
      oe_cnt   <= '0;
      drive_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      ce_cnt   <= ce_n_i ? '0 : bump(ce_cnt);
      oe_cnt   <= oe_n_i ? '0 : bump(oe_cnt);
      drive_o  <= !ce_n_i && !oe_n_i && pgm_n_i;
      reject_o <= reject_o | (pulse && many_low);
    end
  end

  assign valid_o = drive_o && (ce_cnt >= ACW'(CE_ACC)) && (oe_cnt >= ACW'(OE_ACC));
endmodule

// File: rtl/otp_byte_rom.sv
`timescale 1ns/1ps
module otp_byte_rom
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_CYC    = 3,
  parameter int CE_LOW_MIN  = 15,
  parameter int CE_HIGH_MIN = 5,
  parameter int CYCLE_MIN   = 22,
  parameter int CE_ACC      = 4,
  parameter int OE_ACC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              pgm_n_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_drive_o,
  output logic              dq_valid_o,
  output logic              prog_reject_o,
  output logic [RULE_N-1:0] rule_err_o
);
  logic              ce_fall, ce_rise, ce_was_low;
  logic [ADDR_W-1:0] addr_held;
  logic              fuse_wr;
  logic [DATA_W-1:0] fuse_mask, fuse_word;

  otp_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
    .ce_fall_o(ce_fall), .ce_rise_o(ce_rise), .ce_was_low_o(ce_was_low),
    .addr_held_o(addr_held)
  );

  otp_rule_check #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .CE_LOW_MIN(CE_LOW_MIN), .CE_HIGH_MIN(CE_HIGH_MIN), .CYCLE_MIN(CYCLE_MIN)
  ) u_rules (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
    .ce_fall_i(ce_fall), .ce_rise_i(ce_rise), .addr_held_i(addr_held),
    .rule_err_o(rule_err_o)
  );

  otp_port_ctrl #(.DATA_W(DATA_W), .CE_ACC(CE_ACC), .OE_ACC(OE_ACC)) u_port (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .pgm_n_i(pgm_n_i), .ce_was_low_i(ce_was_low), .dq_i(dq_i),
    .wr_en_o(fuse_wr), .set_mask_o(fuse_mask), .reject_o(prog_reject_o),
    .drive_o(dq_drive_o), .valid_o(dq_valid_o)
  );

  otp_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fuses (
    .clk(clk), .rst_n(rst_n), .wr_en_i(fuse_wr), .addr_i(addr_held),
    .set_mask_i(fuse_mask), .rd_data_o(fuse_word)
  );

  assign dq_o = dq_valid_o ? fuse_word : '0;
endmodule

// File: rtl/otp_byte_rom_chk.sv
`timescale 1ns/1ps
module otp_byte_rom_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              pgm_n_i,
  input logic [DATA_W-1:0] dq_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_drive_o,
  input logic              dq_valid_o,
  input logic              prog_reject_o,
  input logic [4:0]        rule_err_o,
  input logic [ADDR_W-1:0] addr_held,
  input logic              fuse_wr
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_HELD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ce_n_i && !$past(ce_n_i)) |=> $stable(addr_held)); // R1
  AST_DRIVE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dq_drive_o) |-> $past(!ce_n_i && !oe_n_i && pgm_n_i)); // R2
  AST_NO_DRIVE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ce_n_i)) |-> !dq_drive_o); // R2
  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid_o |-> dq_drive_o); // R3
  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid_o |-> (dq_o == '0)); // R3
  AST_FUSES_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dq_valid_o && $past(dq_valid_o) && $stable(addr_held))
      |-> ((dq_o & $past(dq_o)) == $past(dq_o))); // R6
  AST_MULTI_LOW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ce_n_i && !$past(ce_n_i) && !pgm_n_i && oe_n_i && ($countones(~dq_i) > 1))
      |=> prog_reject_o); // R7
  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_reject_o |=> prog_reject_o); // R7
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i || pgm_n_i) |-> !fuse_wr); // R8
  AST_RULE_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((rule_err_o & $past(rule_err_o)) == $past(rule_err_o))); // R9
endmodule

bind otp_byte_rom otp_byte_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .pgm_n_i(pgm_n_i),
  .dq_i(dq_i), .dq_o(dq_o), .dq_drive_o(dq_drive_o), .dq_valid_o(dq_valid_o),
  .prog_reject_o(prog_reject_o), .rule_err_o(rule_err_o),
  .addr_held(addr_held), .fuse_wr(fuse_wr)
);

// File: tb/otp_byte_rom_test.sv
`timescale 1ns/1ps
module otp_byte_rom_test;
  localparam int AW = 13;
  localparam int CE_ACC = 4;
  localparam int OE_ACC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ce_n_i = 1'b1, oe_n_i = 1'b1, pgm_n_i = 1'b1;
  logic [7:0]    dq_i = 8'hFF;
  logic [7:0]    dq_o;
  logic          dq_drive_o, dq_valid_o, prog_reject_o;
  logic [4:0]    rule_err_o;

  always #2 clk = ~clk;

  otp_byte_rom uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .pgm_n_i(pgm_n_i), .dq_i(dq_i), .dq_o(dq_o), .dq_drive_o(dq_drive_o),
    .dq_valid_o(dq_valid_o), .prog_reject_o(prog_reject_o), .rule_err_o(rule_err_o)
  );

  typedef struct { logic [7:0] data; string tag; } exp_t;
  exp_t       sb_q[$];
  logic [7:0] model [int];
  int         n_chk = 0, n_fail = 0;
  logic       prev_v = 1'b0;
  bit         done = 1'b0;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] peek(input int a);
    return model.exists(a) ? model[a] : 8'h00;
  endfunction

  // monitor: pops the scoreboard on each rise of the valid strobe
  always @(negedge clk) begin
    if (rst_n && dq_valid_o && !prev_v) begin
      if (sb_q.size() == 0) check_eq("R3 unexpected valid", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check_eq(e.tag, dq_o, e.data);
      end
    end
    prev_v <= dq_valid_o;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ce_n_i = 1; oe_n_i = 1; pgm_n_i = 1; dq_i = 8'hFF; addr_i = '0;
    model.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  // oe already low when ce falls: valid follows the ce count
  task automatic read_ce_first(input int a, input string tag);
    @(negedge clk); addr_i = AW'(a); oe_n_i = 0;
    repeat (3) @(negedge clk);
    ce_n_i = 0;
    sb_q.push_back('{peek(a), tag});
    repeat (CE_ACC - 1) @(negedge clk);
    check_eq("R2 drive during read", dq_drive_o, 1);
    check_eq("R3 not yet valid", dq_valid_o, 0);
    @(negedge clk);
    check_eq("R3 valid after ce access", dq_valid_o, 1);
    repeat (16 - CE_ACC) @(negedge clk);
    ce_n_i = 1; oe_n_i = 1;
    repeat (8) @(negedge clk);
  endtask

  // oe falls late; the address pins move after the hold window
  task automatic read_oe_late(input int a, input string tag);
    @(negedge clk); addr_i = AW'(a); oe_n_i = 0;
    repeat (3) @(negedge clk);
    check_eq("R2 no drive with ce high", dq_drive_o, 0);
    oe_n_i = 1; ce_n_i = 0;
    repeat (CE_ACC + 1) @(negedge clk);
    check_eq("R2 high-Z with oe high", dq_drive_o, 0);
    addr_i = AW'(a + 1);
    oe_n_i = 0;
    sb_q.push_back('{peek(a), tag});
    repeat (OE_ACC - 1) @(negedge clk);
    check_eq("R3 waits for oe access", dq_valid_o, 0);
    @(negedge clk);
    check_eq("R3 valid after oe access", dq_valid_o, 1);
    repeat (16 - CE_ACC - 1 - OE_ACC) @(negedge clk);
    check_eq("R1 word kept after address change", dq_o, peek(a));
    ce_n_i = 1; oe_n_i = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic prog(input int a, input logic [7:0] pat);
    @(negedge clk); addr_i = AW'(a); oe_n_i = 1;
    repeat (3) @(negedge clk);
    ce_n_i = 0;
    repeat (2) @(negedge clk);
    pgm_n_i = 0; dq_i = pat;
    @(negedge clk);
    pgm_n_i = 1; dq_i = 8'hFF;
    if ($countones(~pat) == 1) model[a] = peek(a) | ~pat;
    repeat (13) @(negedge clk);
    ce_n_i = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic prog_deselected(input int a, input logic [7:0] pat);
    @(negedge clk); addr_i = AW'(a); oe_n_i = 1;
    repeat (3) @(negedge clk);
    pgm_n_i = 0; dq_i = pat;
    repeat (3) @(negedge clk);
    pgm_n_i = 1; dq_i = 8'hFF;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_eq("R2 reset drive", dq_drive_o, 0);
    check_eq("R3 reset valid", dq_valid_o, 0);
    check_eq("R7 reset reject", prog_reject_o, 0);
    check_eq("R9 reset rule flags", rule_err_o, 0);

    read_ce_first(0, "R4 blank first word");
    read_ce_first(8191, "R4 blank last word");
    prog(5, 8'hFE);
    read_ce_first(5, "R5 bit0 set");
    prog(5, 8'h7F);
    read_ce_first(5, "R6 bit7 added, bit0 kept");
    prog(5, 8'hFF);
    check_eq("R7 no-line pulse not flagged", prog_reject_o, 0);
    read_ce_first(5, "R7 no-line pulse no write");
    prog(5, 8'h00);
    check_eq("R7 multi-line pulse flagged", prog_reject_o, 1);
    read_ce_first(5, "R7 multi-line pulse no write");
    prog_deselected(9, 8'hEF);
    read_ce_first(9, "R8 write with ce high ignored");
    prog(8191, 8'hF7);
    read_ce_first(8191, "R5 last word bit3");
    read_ce_first(8190, "R5 neighbour untouched");
    read_oe_late(5, "R1 captured word read");
    check_eq("R13 no flags with legal timing", rule_err_o, 0);

    // R9 setup: address and chip enable change together
    do_reset();
    addr_i = 200; ce_n_i = 0;
    repeat (16) @(negedge clk); ce_n_i = 1; repeat (8) @(negedge clk);
    check_eq("R9 setup flag", rule_err_o, 5'b00001);

    // R10 hold: address moves on the edge after capture
    do_reset();
    addr_i = 100; repeat (3) @(negedge clk);
    ce_n_i = 0; @(negedge clk); addr_i = 101;
    repeat (16) @(negedge clk); ce_n_i = 1; repeat (8) @(negedge clk);
    check_eq("R10 hold flag", rule_err_o, 5'b00010);

    // R11 low width too short
    do_reset();
    repeat (3) @(negedge clk);
    ce_n_i = 0; repeat (5) @(negedge clk); ce_n_i = 1; repeat (8) @(negedge clk);
    check_eq("R11 low width flag", rule_err_o, 5'b00100);

    // R12 high width too short, cycle still long enough
    do_reset();
    repeat (3) @(negedge clk);
    ce_n_i = 0; repeat (20) @(negedge clk); ce_n_i = 1; repeat (2) @(negedge clk);
    ce_n_i = 0; repeat (20) @(negedge clk); ce_n_i = 1; repeat (8) @(negedge clk);
    check_eq("R12 high width flag", rule_err_o, 5'b01000);

    // R13 both widths at minimum, cycle too short
    do_reset();
    repeat (3) @(negedge clk);
    ce_n_i = 0; repeat (15) @(negedge clk); ce_n_i = 1; repeat (5) @(negedge clk);
    ce_n_i = 0; repeat (16) @(negedge clk); ce_n_i = 1; repeat (8) @(negedge clk);
    check_eq("R13 cycle flag", rule_err_o, 5'b10000);

    check_eq("R3 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule